// File: doc/BRIEF.md
# Recursive Tri-State Word Memory

This block is a parameterised random-access store. It holds 2^ADDR_BITS words of DATA_BITS bits each. A single bidirectional data bus carries write data in and read data out. An enable input and a direction input control every access. When the block is enabled for a read, it drives the bus with the addressed word. In every other state it leaves the bus high-impedance, so other agents or a pull network may own the lines.

The structure is built bottom-up. The smallest piece is a one-bit cell, whose stored value is updated in set/reset form. A row of such cells sharing enable and direction forms a word. Depth grows recursively: a memory with one more address bit is made of two half-size memories. Its top address bit, combined with enable, enables exactly one half. The remaining address bits are routed to both halves. Writes take effect on the rising clock edge. Reads are combinational from address and controls to the bus.

Top module: `tsram_top`

## Requirements
- R1: A word written at an address reads back unchanged from that same address, for every one of the 2^ADDR_BITS addresses.
- R2: The block drives the data bus only when en=1 and wr=0. With en=0, or with en=1 and wr=1, every bus line is high-impedance, and a pulled-up bus reads all ones.
- R3: With en=1 and wr=1, the value present on the bus is stored into the addressed word at the next rising clock edge.
- R4: With en=1 and wr=0, the addressed word appears on the bus in the same cycle, with no clock edge needed.
- R5: A write to one address leaves every other address unchanged.
- R6: With en=0, no word changes, whatever the values on wr, the address and the bus.
- R7: An asynchronous active-low reset (rst_n=0) clears every word to zero.
- R8: The most significant address bit chooses the half: 0 selects the lower half and 1 selects the upper half. Two addresses that differ only in that bit hold independent words, and at most one half ever drives the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset clearing all words |
| en | input | 1 | Access enable; 0 isolates the memory from the bus |
| wr | input | 1 | Direction: 1 write (bus into memory), 0 read (memory onto bus) |
| addr | input | ADDR_BITS | Word address; the top bit selects the half |
| data | inout | DATA_BITS | Shared bidirectional data bus |

## Verification
A corrupted cell or a wrong half-select is invisible until the affected address is read. The bad value then appears on the bus within the same cycle as the read. For this reason the bench reads back every address after each disturbing write, rather than only the address it wrote. A driver that fails to release shows up at once as a bus that no longer reads the pulled-up all-ones value while the block is disabled or writing. A mis-routed top address bit shows up as two addresses that differ only in that bit aliasing to one word.

// File: rtl/tsram_pkg.sv
`timescale 1ns/1ps
package tsram_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } tsram_op_e;

   localparam int unsigned MAX_ADDR_BITS = 12;

   function automatic int unsigned words_of(input int unsigned abits);
      return 32'd1 << abits;
   endfunction
endpackage

// File: rtl/tsram_cell.sv
`timescale 1ns/1ps
module tsram_cell
   import tsram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic wr,
   inout  wire  bit_io,
   output logic drv
);
   logic q;
   logic set_c, clr_c;
   tsram_op_e op;

   assign op    = tsram_op_e'(wr);
   assign set_c = en && (op == OP_WRITE) && bit_io;
   assign clr_c = en && (op == OP_WRITE) && !bit_io;
   assign drv   = en && (op == OP_READ);
   assign bit_io = drv ? q : 1'bz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_c) q <= 1'b1;
      else if (clr_c) q <= 1'b0;
   end

   // R3: a write captures the bus level
   p_write_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr) |=> (q == $past(bit_io)));
   // R6: without a write the bit holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && wr) |=> $stable(q));
endmodule

// File: rtl/tsram_word.sv
`timescale 1ns/1ps
module tsram_word #(
   parameter int unsigned DBITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr,
   inout  wire  [DBITS-1:0] data,
   output logic             drv
);
   logic [DBITS-1:0] bit_drv;

   if (DBITS < 1) begin : g_bad_width
      $error("tsram_word: DBITS must be at least 1");
   end

   for (genvar i = 0; i < DBITS; i++) begin : g_bit
      tsram_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en),
         .wr     (wr),
         .bit_io (data[i]),
         .drv    (bit_drv[i])
      );
   end

   assign drv = |bit_drv;

   // R2: all bit drivers of a word switch together
   p_bits_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_drv == '0) || (bit_drv == '1));
endmodule

// File: rtl/tsram_bank.sv
`timescale 1ns/1ps
module tsram_bank #(
   parameter int unsigned ABITS = 4,
   parameter int unsigned DBITS = 8,
   localparam int unsigned AW   = (ABITS > 0) ? ABITS : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   inout  wire  [DBITS-1:0] data,
   output logic             drv
);
   if (ABITS == 0) begin : g_leaf
      wire leaf_addr_unused = ^addr;
      tsram_word #(.DBITS(DBITS)) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (en),
         .wr    (wr),
         .data  (data),
         .drv   (drv)
      );
   end else begin : g_split
      localparam int unsigned CAW = (ABITS > 1) ? ABITS - 1 : 1;
      logic           top_bit;
      logic           en_lo, en_hi;
      logic           drv_lo, drv_hi;
      logic [CAW-1:0] sub_addr;

      assign top_bit = addr[ABITS-1];
      assign en_lo   = en && !top_bit;
      assign en_hi   = en &&  top_bit;

      if (ABITS > 1) begin : g_route
         assign sub_addr = addr[ABITS-2:0];
      end else begin : g_none
         assign sub_addr = '0;
      end

      tsram_bank #(.ABITS(ABITS-1), .DBITS(DBITS)) u_lo (
         .clk (clk), .rst_n (rst_n), .en (en_lo), .wr (wr),
         .addr (sub_addr), .data (data), .drv (drv_lo)
      );
      tsram_bank #(.ABITS(ABITS-1), .DBITS(DBITS)) u_hi (
         .clk (clk), .rst_n (rst_n), .en (en_hi), .wr (wr),
         .addr (sub_addr), .data (data), .drv (drv_hi)
      );

      assign drv = drv_lo || drv_hi;

      // R8: never both halves on the bus
      p_one_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(drv_lo && drv_hi));
      // R8: the lower half drives only for top address bit 0
      p_lo_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
         drv_lo |-> !addr[ABITS-1]);
      p_hi_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
         drv_hi |-> addr[ABITS-1]);
   end
endmodule

// File: rtl/tsram_top.sv
`timescale 1ns/1ps
module tsram_top #(
   parameter int unsigned ADDR_BITS = 4,
   parameter int unsigned DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 wr,
   input  logic [ADDR_BITS-1:0] addr,
   inout  wire  [DATA_BITS-1:0] data
);
   localparam int unsigned WORDS = tsram_pkg::words_of(ADDR_BITS);

   if (ADDR_BITS < 1 || ADDR_BITS > tsram_pkg::MAX_ADDR_BITS) begin : g_bad_depth
      $error("tsram_top: ADDR_BITS out of range");
   end
   if (WORDS * DATA_BITS > 4096) begin : g_bad_size
      $error("tsram_top: too many cells");
   end

   logic bank_drv;

   tsram_bank #(.ABITS(ADDR_BITS), .DBITS(DATA_BITS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .wr    (wr),
      .addr  (addr),
      .data  (data),
      .drv   (bank_drv)
   );

   // R2: bus released unless an enabled read
   p_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && !wr) |-> !bank_drv);
   // R4: an enabled read always reaches the bus
   p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wr) |-> bank_drv);
endmodule

// File: tb/tb_tsram_top.sv
`timescale 1ns/1ps
module tb_tsram_top;
   localparam int AB = 4;
   localparam int DB = 8;
   localparam int NW = 1 << AB;
   localparam int NV = 8;
   localparam logic [AB-1:0] V_ADDR [NV] = '{4'h0, 4'hF, 4'h3, 4'hB, 4'h7, 4'h8, 4'h1, 4'hE};
   localparam logic [DB-1:0] V_DATA [NV] = '{8'hA5, 8'h00, 8'h3C, 8'hC3, 8'hFF, 8'h01, 8'h80, 8'h5A};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic wr = 1'b0;
   logic [AB-1:0] addr = '0;
   logic tb_oe = 1'b0;
   logic [DB-1:0] tb_val = '0;
   wire  [DB-1:0] data;
   logic [DB-1:0] model [NW];
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   assign data = tb_oe ? tb_val : 'z;
   for (genvar i = 0; i < DB; i++) begin : g_pu
      pullup pu_i (data[i]);
   end

   tsram_top #(.ADDR_BITS(AB), .DATA_BITS(DB)) dut (
      .clk (clk), .rst_n (rst_n), .en (en), .wr (wr), .addr (addr), .data (data)
   );

   task automatic chk(input string req, input logic [DB-1:0] act, input logic [DB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AB-1:0] a, input logic [DB-1:0] v);
      @(negedge clk);
      addr = a; en = 1'b1; wr = 1'b1; tb_oe = 1'b1; tb_val = v;
      @(negedge clk);
      en = 1'b0; wr = 1'b0; tb_oe = 1'b0;
   endtask

   task automatic do_read(input logic [AB-1:0] a, output logic [DB-1:0] v);
      @(negedge clk);
      addr = a; en = 1'b1; wr = 1'b0; tb_oe = 1'b0;
      #2 v = data;
      @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [DB-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7: reset state, every word zero (driven zero, not pulled high)
      for (int a = 0; a < NW; a++) begin
         do_read(a[AB-1:0], rd);
         chk("R7 reset word", rd, '0);
         model[a] = '0;
      end

      // R1/R3: table walk, write all then read all
      for (int i = 0; i < NV; i++) begin
         do_write(V_ADDR[i], V_DATA[i]);
         model[V_ADDR[i]] = V_DATA[i];
      end
      for (int i = 0; i < NV; i++) begin
         do_read(V_ADDR[i], rd);
         chk("R1 R3 table readback", rd, V_DATA[i]);
      end

      // R8: addresses differing only in top bit are independent
      do_read(4'h3, rd); chk("R8 lower half", rd, 8'h3C);
      do_read(4'hB, rd); chk("R8 upper half", rd, 8'hC3);

      // R4: read data present in the same cycle, before any edge
      @(negedge clk);
      addr = 4'hE; en = 1'b1; wr = 1'b0;
      #1 chk("R4 same cycle", data, 8'h5A);
      addr = 4'h0;
      #1 chk("R4 address change", data, 8'hA5);
      @(negedge clk); en = 1'b0;

      // R5: fill all, write one, verify the rest
      for (int a = 0; a < NW; a++) begin
         do_write(a[AB-1:0], DB'(8'h10 + a));
         model[a] = DB'(8'h10 + a);
      end
      do_write(4'h5, 8'h00);
      model[5] = 8'h00;
      for (int a = 0; a < NW; a++) begin
         do_read(a[AB-1:0], rd);
         chk("R5 isolation", rd, model[a]);
      end

      // R2: bus floats when disabled
      @(negedge clk);
      addr = 4'h5; en = 1'b0; wr = 1'b0; tb_oe = 1'b0;
      #2 chk("R2 float disabled", data, 8'hFF);
      // R2: bus floats during an enabled write with no external driver
      addr = 4'h5; en = 1'b1; wr = 1'b1;
      #1 chk("R2 float on write", data, 8'hFF);
      @(negedge clk);
      en = 1'b0; wr = 1'b0;
      model[5] = 8'hFF;
      do_read(4'h5, rd); chk("R3 pulled value stored", rd, 8'hFF);

      // R6: disabled write attempt changes nothing
      @(negedge clk);
      addr = 4'h9; en = 1'b0; wr = 1'b1; tb_oe = 1'b1; tb_val = 8'hE7;
      repeat (2) @(negedge clk);
      wr = 1'b0; tb_oe = 1'b0;
      do_read(4'h9, rd); chk("R6 disabled write ignored", rd, model[9]);

      // R7: reset mid-run clears contents
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      do_read(4'h9, rd); chk("R7 mid reset", rd, 8'h00);
      do_read(4'hF, rd); chk("R7 mid reset top", rd, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule